// File: doc/BRIEF.md
# Double-Width Single-Port Synchronous RAM

This block is a single-port synchronous memory that returns a 72-bit word per access. It holds 256 words. Inside, it keeps one dual-port array of 36-bit entries that has twice as many entries as the user address space. Both ports of that array run on every enabled edge. The user address goes to both ports. One port appends a constant 0 as the top address bit and the other appends a constant 1, so each port stores or returns its own half of the wide word.

A user drives a clock enable, a read/write select, an address and write data. The word read appears in an output register one clock after the edge that sampled the request. A write also loads the written word into that register (write-first). With the enable low, neither the array nor the output register changes. A synchronous reset clears only the output register. The array contents are undefined until written.

Top module: `wide_sp_ram`

## Requirements
- R1: All accesses are synchronous. Address, select and data are sampled on the rising clock edge, and `rdData` changes only on that edge, one cycle after the request.
- R2: With `clkEn`=1 and `wrSel`=0, the edge loads `rdData` with the 72-bit word most recently written to `addr`.
- R3: With `clkEn`=1 and `wrSel`=1, the edge stores `wrData` at `addr`. The same edge loads `rdData` with `wrData` (write-first).
- R4: With `clkEn`=0, the edge neither writes the array nor changes `rdData`, whatever `wrSel`, `addr` and `wrData` hold.
- R5: `wrSel` alone chooses between writing (1) and reading (0). There is no other strobe.
- R6: Bits [35:0] of a word are stored at internal entry {1'b0, addr}, and bits [71:36] at entry {1'b1, addr}. Writing one user address leaves every other user address unchanged, including all 256 addresses written back to back.
- R7: A synchronous reset (`rst`=1 on an edge) sets `rdData` to zero and leaves the array contents untouched.
- R8: Both internal ports always carry the same operation and the same user address, and their internal entries differ in the top address bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the read register, active high |
| clkEn | input | 1 | Clock enable; when low the edge does nothing |
| wrSel | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wrData | input | 72 | Word to write |
| rdData | output | 72 | Registered read data |

## Verification
Four kinds of traffic are run.

- Writes to all 256 addresses with distinct patterns, followed by reads of every address. This separates correct half placement and address decoding from aliasing or swapped halves.
- Back-to-back write then read at one address, and writes whose old and new contents differ. These separate write-first from read-first behaviour.
- Cycles with the enable low and changing inputs. These show that neither a write nor an output update leaks through.
- A reset in the middle of the run, followed by reads. This shows that reset clears only the register and not the stored words.

// File: rtl/wide_sp_ram_pkg.sv
package wide_sp_ram_pkg;
  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic rdLoad;
    logic clrOut;
  } ramCtl_t;
endpackage

// File: rtl/wide_sp_ram_ctrl.sv
module wide_sp_ram_ctrl
  import wide_sp_ram_pkg::*;
(
  input  logic    rst,
  input  logic    clkEn,
  input  logic    wrSel,
  output ramCtl_t ctl
);
  always_comb begin
    ctl.clrOut = rst;
    ctl.rdLoad = clkEn && !rst;
    ctl.wrLo   = clkEn && wrSel;
    ctl.wrHi   = clkEn && wrSel;
  end
endmodule

// File: rtl/wide_sp_ram_dp.sv
module wide_sp_ram_dp
  import wide_sp_ram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 36
) (
  input  logic                clk,
  input  ramCtl_t             ctl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] wrData,
  output logic [2*HALF_W-1:0] rdData
);
  localparam int ENTRIES = 2 ** (ADDR_W + 1);
  localparam int WORD_W  = 2 * HALF_W;

  logic [HALF_W-1:0] store [ENTRIES];
  logic [ADDR_W:0]   portAddr [2];
  logic [HALF_W-1:0] portRd   [2];
  logic [1:0]        portWr;

  assign portWr = {ctl.wrHi, ctl.wrLo};

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign portAddr[p] = {1'(p), addr};
    always_ff @(posedge clk) begin
      if (portWr[p]) store[portAddr[p]] <= wrData[p*HALF_W +: HALF_W];
    end
    always_comb begin
      portRd[p] = portWr[p] ? wrData[p*HALF_W +: HALF_W] : store[portAddr[p]];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clrOut)      rdData <= '0;
    else if (ctl.rdLoad) rdData <= {portRd[1], portRd[0]};
  end

  logic [WORD_W-1:0] unusedW;
  assign unusedW = '0;
endmodule

// File: rtl/wide_sp_ram.sv
module wide_sp_ram
  import wide_sp_ram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clkEn,
  input  logic                wrSel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] wrData,
  output logic [2*HALF_W-1:0] rdData
);
  ramCtl_t ctl;

  wide_sp_ram_ctrl i_ctrl (
    .rst(rst), .clkEn(clkEn), .wrSel(wrSel), .ctl(ctl)
  );

  wide_sp_ram_dp #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) i_dp (
    .clk(clk), .ctl(ctl), .addr(addr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/wide_sp_ram_checker.sv
module wide_sp_ram_checker
  import wide_sp_ram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 36
) (
  input logic                clk,
  input logic                rst,
  input logic                clkEn,
  input logic                wrSel,
  input logic [2*HALF_W-1:0] wrData,
  input logic [2*HALF_W-1:0] rdData,
  input ramCtl_t             ctl
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> rdData == '0) else $error("reset"); // R7
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst) !clkEn |=> $stable(rdData)) else $error("hold"); // R4
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst) (clkEn && wrSel) |=> rdData == $past(wrData)) else $error("wf"); // R3
  AST_PORTS_MATCH: assert property (@(posedge clk) ctl.wrLo == ctl.wrHi) else $error("ports"); // R8
  AST_NO_WRITE_OFF: assert property (@(posedge clk) !clkEn |-> !(ctl.wrLo || ctl.wrHi)) else $error("wr"); // R5
endmodule

bind wide_sp_ram wide_sp_ram_checker #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) i_chk (
  .clk(clk), .rst(rst), .clkEn(clkEn), .wrSel(wrSel),
  .wrData(wrData), .rdData(rdData), .ctl(ctl)
);

// File: tb/test_wide_sp_ram.sv
module test_wide_sp_ram;
  logic        clk = 0;
  logic        rst, clkEn, wrSel;
  logic [7:0]  addr;
  logic [71:0] wrData, rdData;
  logic [71:0] model [256];
  bit          known [256];
  logic [71:0] expOut;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  wide_sp_ram i_wide_sp_ram (
    .clk(clk), .rst(rst), .clkEn(clkEn), .wrSel(wrSel),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(string req);
    checks++;
    if (rdData !== expOut) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, rdData, expOut);
    end
  endtask

  // One clock: drive at negedge, apply edge to model, sample after edge.
  task automatic op(input bit r, input bit en, input bit w, input logic [7:0] a,
                    input logic [71:0] d, input string req);
    @(negedge clk);
    rst = r; clkEn = en; wrSel = w; addr = a; wrData = d;
    @(posedge clk);
    if (r) expOut = '0;
    else if (en) begin
      if (w) begin model[a] = d; known[a] = 1; expOut = d; end
      else expOut = model[a];
    end
    #1;
    if (r || !en || w || known[a]) check(req);
  endtask

  function automatic logic [71:0] pat(int i);
    return {8'(i) ^ 8'h5A, 28'(i * 7919), 36'(i * 104729 + 3)};
  endfunction

  initial begin
    rst = 1; clkEn = 0; wrSel = 0; addr = 0; wrData = 0;
    expOut = '0;
    op(1, 0, 0, 0, 0, "R7 reset");
    for (int i = 0; i < 256; i++) op(0, 1, 1, 8'(i), pat(i), "R3 write-first");
    for (int i = 0; i < 256; i++) op(0, 1, 0, 8'(i), 0, "R6 readback all");
    for (int i = 255; i >= 0; i -= 17) op(0, 1, 0, 8'(i), 0, "R2 read descending");
    op(0, 1, 1, 8'h33, {36'hAAAAAAAAA, 36'h555555555}, "R3 write new");
    op(0, 1, 0, 8'h33, 0, "R1 read after write");
    op(0, 1, 1, 8'h33, {36'h123456789, 36'hFEDCBA987}, "R3 overwrite write-first");
    op(0, 1, 0, 8'h32, 0, "R6 neighbour untouched");
    op(0, 1, 0, 8'h34, 0, "R6 neighbour untouched");
    op(0, 0, 1, 8'h33, {72{1'b1}}, "R4 disabled write hold");
    op(0, 0, 0, 8'h10, 0, "R4 disabled read hold");
    op(0, 1, 0, 8'h33, 0, "R4 no write leaked");
    op(0, 1, 1, 8'h00, {36'h0, 36'hFFFFFFFFF}, "R6 low half only");
    op(0, 1, 0, 8'h00, 0, "R6 low half placement");
    op(0, 1, 1, 8'hFF, {36'hFFFFFFFFF, 36'h0}, "R6 high half only");
    op(0, 1, 0, 8'hFF, 0, "R6 high half placement");
    op(0, 0, 0, 8'h00, 0, "R5 select ignored when disabled");
    op(1, 1, 0, 8'h33, 0, "R7 reset clears out");
    op(0, 1, 0, 8'h33, 0, "R7 array kept over reset");
    for (int i = 0; i < 40; i++)
      op(0, (i % 3) != 0, i[0], 8'(i * 37), pat(i + 500), "R1 mixed traffic");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog got=%0d exp<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule